// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block gathers interrupt requests for a small symmetric-multiprocessing cluster of four CPUs and sixty-four interrupt IDs and raises one interrupt line per CPU. The ID space has three classes. IDs 0 to 15 are software interrupts, which CPUs raise for each other. IDs 16 to 31 are private: each CPU has its own copy, driven by its own input pins. IDs 32 to 63 are shared, and a route word sends each one to a single chosen CPU.

Software runs the block through a simple memory-mapped register port. The port has one global region and one local window per CPU. Each CPU uses its window to enable and disable IDs by writing the ID number, to claim the ID it should service, to check whether more work is waiting, to complete an ID, and to send inter-processor interrupts to a set of CPUs. When several IDs compete, the lowest ID wins. The port has no back-pressure: every access is taken in the cycle it is presented, and a read answers one cycle later on a valid strobe.

Top module: `mpic_top`

## Requirements
- R1: After reset, all enables, active marks, software pending bits and route words are clear. Every `irq_out` bit is low, and the global control, route and local control registers read 0.
- R2: `irq_out[c]` is high exactly when three things hold: the global enable (bit 0 at address 0x0000) is set, CPU c's local enable is set, and some ID is pending for CPU c, enabled for CPU c and not active on CPU c.
- R3: Writing an ID in bits [5:0] to local offset 0xa0 enables that ID for the CPU owning the window. Writing it to offset 0xa4 disables it. A pending but disabled ID does not raise the line.
- R4: A read of local offset 0x6c returns the lowest ID that qualifies under R2, zero-extended, and marks it active. If the ID is a software ID, the read also clears its pending bit. With the line low, the read returns 0xFFFFFFFF and changes nothing.
- R5: A read of local offset 0x68 returns the line state in bit 31 and, when that bit is set, the ID a claim would return in bits [5:0]. All other bits read 0, and the read has no side effect.
- R6: Writing an ID to local offset 0xb4 clears its active mark. An input that is still high then raises the line again.
- R7: The route word for shared ID n sits at 0x1000 + 4*(n-32). It holds the target CPU in bits [1:0] and a delivery enable in bit 31, and it reads back as written in those bits. A shared input counts as pending only for the target CPU, and only while bit 31 is set.
- R8: A write to local offset 0x60 of any window carries a software ID in bits [3:0] and a CPU mask in bits [15:8]. Each CPU c whose mask bit 8+c is set gets that software ID pending. Mask bits for CPUs that do not exist are ignored. A software ID stays pending until it is claimed.
- R9: Private ID 16+k of CPU c is driven by `ppi_in[c*16+k]` and is pending for CPU c only.
- R10: Local windows start at 0x8000 + 0x1000*c. Bit 0 at local offset 0x0 is that CPU's interface enable, and it reads back as written.
- R11: A read presented with `bus_en` high and `bus_we` low gives `bus_rvalid` high with its data on the next cycle. `bus_rvalid` stays low in every other cycle. A write takes effect at the clock edge that accepts it.
- R12: Shared and private inputs are level-sensitive and are not latched. If the input drops before the claim, the ID is no longer pending. A claim sees the input levels present at the edge that accepts the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe, accepted every cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| ppi_in | input | 64 | Private interrupt levels, 16 per CPU |
| spi_in | input | 32 | Shared interrupt levels, bit n-32 for ID n |
| irq_out | output | 4 | Interrupt line, one per CPU |

## Verification
Two events can land in the same cycle: a claim read and a change on a level input with a lower ID. The bench starts with a shared ID waiting on CPU 0. It then raises a lower private input in the very cycle that carries the claim read. The claim must return the newly raised lower ID, with the shared ID still waiting behind it. The behavioural reference model samples the inputs at the same edge, and it confirms both the returned ID and the line state on every cycle that follows.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
  // local window register offsets
  localparam logic [11:0] OFF_CTRL  = 12'h000;
  localparam logic [11:0] OFF_IPI   = 12'h060;
  localparam logic [11:0] OFF_PEEK  = 12'h068;
  localparam logic [11:0] OFF_CLAIM = 12'h06c;
  localparam logic [11:0] OFF_SETEN = 12'h0a0;
  localparam logic [11:0] OFF_CLREN = 12'h0a4;
  localparam logic [11:0] OFF_DONE  = 12'h0b4;
  // global region pages (address bits [14:12])
  localparam logic [2:0]  PAGE_CTRL  = 3'd0;
  localparam logic [2:0]  PAGE_ROUTE = 3'd1;
  localparam logic [31:0] NO_CLAIM   = 32'hFFFF_FFFF;
endpackage

// File: rtl/mpic_pick.sv
module mpic_pick #(
  parameter int N = 64,
  parameter int W = 6
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx,
  output logic         vld
);
  // lowest set bit wins: scan downward so the last hit is the lowest
  always_comb begin
    idx = '0;
    vld = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = W'(i);
        vld = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mpic_route.sv
module mpic_route #(
  parameter int NCPU  = 4,
  parameter int NSPI  = 32,
  parameter int CPU_W = 2,
  parameter int IDX_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [CPU_W-1:0]           wr_tgt,
  input  logic                       wr_on,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [31:0]                rd_word,
  input  logic [NSPI-1:0]            spi_in,
  output logic [NCPU-1:0][NSPI-1:0]  hit
);
  logic [NSPI-1:0][CPU_W-1:0] tgt_q;
  logic [NSPI-1:0]            on_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q <= '0;
      on_q  <= '0;
    end else if (wr) begin
      tgt_q[wr_idx] <= wr_tgt;
      on_q[wr_idx]  <= wr_on;
    end
  end

  assign rd_word = {on_q[rd_idx], {(31 - CPU_W){1'b0}}, tgt_q[rd_idx]};

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    for (genvar s = 0; s < NSPI; s++) begin : g_spi
      assign hit[c][s] = spi_in[s] & on_q[s] & (tgt_q[s] == CPU_W'(c));
    end
  end
endmodule

// File: rtl/mpic_cpu_if.sv
module mpic_cpu_if #(
  parameter int NSW  = 16,
  parameter int NPPI = 16,
  parameter int NSPI = 32,
  parameter int ID_W = 6,
  localparam int NID  = NSW + NPPI + NSPI,
  localparam int SW_W = $clog2(NSW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gate,
  input  logic [NPPI-1:0] ppi_lvl,
  input  logic [NSPI-1:0] spi_hit,
  input  logic            set_en,
  input  logic            clr_en,
  input  logic            done,
  input  logic [ID_W-1:0] id_in,
  input  logic [NSW-1:0]  ipi_set,
  input  logic            claim,
  output logic            irq,
  output logic [ID_W-1:0] best_id
);
  logic [NID-1:0] en_q, act_q, pend, cand;
  logic [NSW-1:0] swp_q, sw_clr;
  logic           best_vld, take;

  assign pend = {spi_hit, ppi_lvl, swp_q};
  assign cand = pend & en_q & ~act_q;

  mpic_pick #(.N(NID), .W(ID_W)) u_pick (
    .vec(cand), .idx(best_id), .vld(best_vld)
  );

  assign irq  = gate & best_vld;
  assign take = claim & irq;

  always_comb begin
    sw_clr = '0;
    if (take && (best_id < ID_W'(NSW))) sw_clr[best_id[SW_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      act_q <= '0;
      swp_q <= '0;
    end else begin
      if (set_en) en_q[id_in] <= 1'b1;
      if (clr_en) en_q[id_in] <= 1'b0;
      if (done)   act_q[id_in] <= 1'b0;
      if (take)   act_q[best_id] <= 1'b1;
      swp_q <= (swp_q & ~sw_clr) | ipi_set;
    end
  end
endmodule

// File: rtl/mpic_top.sv
module mpic_top #(
  parameter int NCPU = 4,
  parameter int NSW  = 16,
  parameter int NPPI = 16,
  parameter int NSPI = 32,
  localparam int NID   = NSW + NPPI + NSPI,
  localparam int ID_W  = $clog2(NID),
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IDX_W = $clog2(NSPI),
  localparam int SW_W  = $clog2(NSW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [15:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic                 bus_rvalid,
  output logic [31:0]          bus_rdata,
  input  logic [NCPU*NPPI-1:0] ppi_in,
  input  logic [NSPI-1:0]      spi_in,
  output logic [NCPU-1:0]      irq_out
);
  import mpic_pkg::*;

  logic                        dist_q;
  logic [NCPU-1:0]             cpu_en_q;
  logic [NCPU-1:0][NSPI-1:0]   hit;
  logic [NCPU-1:0][ID_W-1:0]   best_w;
  logic [31:0]                 route_word, rd_val;

  wire        is_loc   = bus_addr[15];
  wire [2:0]  page     = bus_addr[14:12];
  wire [11:0] off      = bus_addr[11:0];
  wire        loc_ok   = is_loc && (page < 3'(NCPU));
  wire [CPU_W-1:0] cidx = bus_addr[12 +: CPU_W];
  wire        route_ok = !is_loc && page == PAGE_ROUTE && off[1:0] == 2'b00 &&
                         (off[11:2] < 10'(NSPI));
  wire        ctrl_hit = !is_loc && page == PAGE_CTRL && off == OFF_CTRL;
  wire        ipi_wr   = bus_en && bus_we && loc_ok && off == OFF_IPI;
  wire [ID_W-1:0] wid  = bus_wdata[ID_W-1:0];

  mpic_route #(.NCPU(NCPU), .NSPI(NSPI), .CPU_W(CPU_W), .IDX_W(IDX_W)) u_route (
    .clk(clk), .rst_n(rst_n),
    .wr(bus_en && bus_we && route_ok),
    .wr_idx(bus_addr[2 +: IDX_W]),
    .wr_tgt(bus_wdata[CPU_W-1:0]),
    .wr_on(bus_wdata[31]),
    .rd_idx(bus_addr[2 +: IDX_W]),
    .rd_word(route_word),
    .spi_in(spi_in),
    .hit(hit)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    wire sel = bus_en && loc_ok && page == 3'(c);
    logic [NSW-1:0] ipi_bits;
    always_comb begin
      ipi_bits = '0;
      if (ipi_wr && bus_wdata[8 + c]) ipi_bits[bus_wdata[SW_W-1:0]] = 1'b1;
    end
    mpic_cpu_if #(.NSW(NSW), .NPPI(NPPI), .NSPI(NSPI), .ID_W(ID_W)) u_if (
      .clk(clk), .rst_n(rst_n),
      .gate(dist_q & cpu_en_q[c]),
      .ppi_lvl(ppi_in[c*NPPI +: NPPI]),
      .spi_hit(hit[c]),
      .set_en(sel && bus_we && off == OFF_SETEN),
      .clr_en(sel && bus_we && off == OFF_CLREN),
      .done(sel && bus_we && off == OFF_DONE),
      .id_in(wid),
      .ipi_set(ipi_bits),
      .claim(sel && !bus_we && off == OFF_CLAIM),
      .irq(irq_out[c]),
      .best_id(best_w[c])
    );
  end

  always_comb begin
    rd_val = '0;
    if (ctrl_hit) rd_val = {31'd0, dist_q};
    else if (route_ok) rd_val = route_word;
    else if (loc_ok) begin
      case (off)
        OFF_CTRL:  rd_val = {31'd0, cpu_en_q[cidx]};
        OFF_PEEK:  rd_val = irq_out[cidx] ? {1'b1, {(31 - ID_W){1'b0}}, best_w[cidx]} : '0;
        OFF_CLAIM: rd_val = irq_out[cidx] ? {{(32 - ID_W){1'b0}}, best_w[cidx]} : NO_CLAIM;
        default:   rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dist_q     <= 1'b0;
      cpu_en_q   <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_en && !bus_we;
      if (bus_en && !bus_we) bus_rdata <= rd_val;
      if (bus_en && bus_we && ctrl_hit) dist_q <= bus_wdata[0];
      if (bus_en && bus_we && loc_ok && off == OFF_CTRL) cpu_en_q[cidx] <= bus_wdata[0];
    end
  end
endmodule

// File: rtl/mpic_check.sv
module mpic_check #(
  parameter int NCPU = 4,
  parameter int NID  = 64,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_en,
  input logic            bus_we,
  input logic [15:0]     bus_addr,
  input logic            bus_rvalid,
  input logic [31:0]     bus_rdata,
  input logic [NCPU-1:0] irq_out,
  input logic            dist_q
);
  wire claim_hit = bus_en && !bus_we && bus_addr[15] &&
                   (bus_addr[14:12] < 3'(NCPU)) && bus_addr[11:0] == 12'h06c;
  wire line = irq_out[bus_addr[12 +: CPU_W]];

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dist_q |-> irq_out == '0);
  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we) |=> bus_rvalid);
  p_rquiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_we) |=> !bus_rvalid);
  p_empty_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_hit && !line) |=> bus_rdata == 32'hFFFF_FFFF);
  p_claim_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_hit && line) |=> bus_rdata < 32'(NID));
endmodule

bind mpic_top mpic_check #(.NCPU(NCPU), .NID(NID)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .dist_q(dist_q)
);

// File: tb/mpic_top_bench.sv
`timescale 1ns/1ps
module mpic_top_bench;
  logic        clk = 0, rst_n = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [15:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic [63:0] ppi_in = 0;
  logic [31:0] spi_in = 0;
  logic [3:0]  irq_out;

  int checks = 0, errors = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  mpic_top u_mpic_top (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .ppi_in(ppi_in), .spi_in(spi_in), .irq_out(irq_out)
  );

  // behavioural reference model
  bit m_en[4][64], m_act[4][64], m_sw[4][16], m_cen[4], m_ron[32];
  bit m_dist, exp_rv;
  int m_tgt[32];
  logic [31:0] exp_rd;

  function automatic bit m_pend(int c, int id);
    if (id < 16) return m_sw[c][id];
    if (id < 32) return ppi_in[c*16 + id - 16];
    return spi_in[id-32] && m_ron[id-32] && m_tgt[id-32] == c;
  endfunction
  function automatic int m_best(int c);
    for (int id = 0; id < 64; id++)
      if (m_pend(c, id) && m_en[c][id] && !m_act[c][id]) return id;
    return -1;
  endfunction
  function automatic bit m_line(int c);
    return m_dist && m_cen[c] && m_best(c) >= 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dist = 0; exp_rv = 0; exp_rd = 0;
      for (int c = 0; c < 4; c++) begin
        m_cen[c] = 0;
        for (int i = 0; i < 64; i++) begin m_en[c][i] = 0; m_act[c][i] = 0; end
        for (int i = 0; i < 16; i++) m_sw[c][i] = 0;
      end
      for (int i = 0; i < 32; i++) begin m_ron[i] = 0; m_tgt[i] = 0; end
    end else begin
      exp_rv = bus_en && !bus_we;
      if (bus_en) begin
        int pg, off, c, id, b;
        pg = bus_addr[14:12]; off = bus_addr[11:0]; c = pg; id = bus_wdata[5:0];
        if (!bus_addr[15]) begin
          if (pg == 0 && off == 0) begin
            if (bus_we) m_dist = bus_wdata[0]; else exp_rd = {31'd0, m_dist};
          end else if (pg == 1 && off[1:0] == 0 && off/4 < 32) begin
            if (bus_we) begin m_tgt[off/4] = bus_wdata[1:0]; m_ron[off/4] = bus_wdata[31]; end
            else exp_rd = {m_ron[off/4], 29'd0, 2'(m_tgt[off/4])};
          end else if (!bus_we) exp_rd = 0;
        end else if (pg < 4) begin
          if (bus_we) begin
            case (off)
              'h000: m_cen[c] = bus_wdata[0];
              'h060: for (int k = 0; k < 4; k++) if (bus_wdata[8+k]) m_sw[k][bus_wdata[3:0]] = 1;
              'h0a0: m_en[c][id] = 1;
              'h0a4: m_en[c][id] = 0;
              'h0b4: m_act[c][id] = 0;
              default: ;
            endcase
          end else begin
            b = m_best(c);
            case (off)
              'h000: exp_rd = {31'd0, m_cen[c]};
              'h068: exp_rd = m_line(c) ? (32'h8000_0000 | 32'(b)) : 0;
              'h06c: if (m_line(c)) begin
                       exp_rd = 32'(b); m_act[c][b] = 1;
                       if (b < 16) m_sw[c][b] = 0;
                     end else exp_rd = 32'hFFFF_FFFF;
              default: exp_rd = 0;
            endcase
          end
        end else if (!bus_we) exp_rd = 0;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    for (int c = 0; c < 4; c++)
      chk(irq_out[c] == m_line(c), "R2", 32'(irq_out[c]), 32'(m_line(c)));
    chk(bus_rvalid == exp_rv, "R11", 32'(bus_rvalid), 32'(exp_rv));
    if (exp_rv) chk(bus_rdata == exp_rd, cur_tag, bus_rdata, exp_rd);
  end

  function automatic logic [15:0] la(int c, int off);
    return 16'(32'h8000 + c * 32'h1000 + off);
  endfunction

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd_exp(logic [15:0] a, logic [31:0] e, string tag);
    @(posedge clk); #1;
    cur_tag = tag; bus_en = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); #1;
    bus_en = 0;
    @(negedge clk);
    chk(bus_rdata == e, tag, bus_rdata, e);
  endtask

  task automatic see(int c, bit v, string tag);
    @(negedge clk);
    chk(irq_out[c] == v, tag, 32'(irq_out[c]), 32'(v));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    see(0, 0, "R1");
    chk(irq_out == 4'b0, "R1", 32'(irq_out), 0);
    rd_exp(16'h0000, 0, "R1");
    rd_exp(16'h1000, 0, "R1");
    rd_exp(la(0, 0), 0, "R1");
    // R10 enables
    wr(16'h0000, 1);
    for (int c = 0; c < 4; c++) wr(la(c, 0), 1);
    rd_exp(16'h0000, 1, "R10");
    rd_exp(la(2, 0), 1, "R10");
    // R9 private input on CPU1 id 20
    wr(la(1, 'ha0), 20);
    ppi_in[1*16 + 4] = 1;
    see(1, 1, "R9");
    see(0, 0, "R9");
    rd_exp(la(1, 'h68), 32'h8000_0014, "R5");
    rd_exp(la(1, 'h6c), 20, "R4");
    see(1, 0, "R4");
    rd_exp(la(1, 'h6c), 32'hFFFF_FFFF, "R4");
    wr(la(1, 'hb4), 20);
    see(1, 1, "R6");
    @(posedge clk); #1 ppi_in[1*16 + 4] = 0;
    see(1, 0, "R12");
    rd_exp(la(1, 'h68), 0, "R5");
    // R7 shared routing: id 40 -> index 8
    wr(16'h1020, 32'h8000_0002);
    rd_exp(16'h1020, 32'h8000_0002, "R7");
    wr(la(2, 'ha0), 40);
    wr(la(3, 'ha0), 40);
    @(posedge clk); #1 spi_in[8] = 1;
    see(2, 1, "R7");
    see(3, 0, "R7");
    wr(16'h1020, 32'h8000_0003);
    see(2, 0, "R7");
    see(3, 1, "R7");
    rd_exp(la(3, 'h6c), 40, "R7");
    wr(la(3, 'hb4), 40);
    wr(16'h1020, 32'h0000_0003);
    see(3, 0, "R7");
    @(posedge clk); #1 spi_in[8] = 0;
    // R8 inter-processor interrupt, mask bits 1,3 and a nonexistent CPU 7
    wr(la(1, 'ha0), 5);
    wr(la(3, 'ha0), 5);
    wr(la(0, 'h60), 32'h0000_8A05);
    see(1, 1, "R8");
    see(3, 1, "R8");
    see(0, 0, "R8");
    rd_exp(la(1, 'h6c), 5, "R8");
    wr(la(1, 'hb4), 5);
    see(1, 0, "R8");
    rd_exp(la(3, 'h6c), 5, "R8");
    wr(la(3, 'hb4), 5);
    // R3 disable / enable by ID
    wr(la(3, 'ha4), 5);
    wr(la(2, 'h60), 32'h0000_0805);
    see(3, 0, "R3");
    wr(la(3, 'ha0), 5);
    see(3, 1, "R3");
    rd_exp(la(3, 'h6c), 5, "R3");
    wr(la(3, 'hb4), 5);
    // R4 lowest ID first across the three classes on CPU0
    wr(la(0, 'ha0), 3);
    wr(la(0, 'ha0), 17);
    wr(la(0, 'ha0), 33);
    wr(16'h1004, 32'h8000_0000);
    @(posedge clk); #1 begin spi_in[1] = 1; ppi_in[1] = 1; end
    wr(la(1, 'h60), 32'h0000_0103);
    rd_exp(la(0, 'h6c), 3, "R4");
    rd_exp(la(0, 'h6c), 17, "R4");
    rd_exp(la(0, 'h6c), 33, "R4");
    rd_exp(la(0, 'h6c), 32'hFFFF_FFFF, "R4");
    @(posedge clk); #1 begin spi_in[1] = 0; ppi_in[1] = 0; end
    wr(la(0, 'hb4), 3);
    wr(la(0, 'hb4), 17);
    wr(la(0, 'hb4), 33);
    see(0, 0, "R6");
    // R2 gating by global and local enables
    @(posedge clk); #1 ppi_in[1] = 1;
    see(0, 1, "R2");
    wr(16'h0000, 0);
    see(0, 0, "R2");
    rd_exp(la(0, 'h6c), 32'hFFFF_FFFF, "R2");
    wr(16'h0000, 1);
    see(0, 1, "R2");
    wr(la(0, 0), 0);
    see(0, 0, "R10");
    wr(la(0, 0), 1);
    rd_exp(la(0, 'h6c), 17, "R2");
    @(posedge clk); #1 ppi_in[1] = 0;
    wr(la(0, 'hb4), 17);
    // R12 same-cycle: lower private input rises with the claim read
    @(posedge clk); #1 spi_in[1] = 1;
    see(0, 1, "R12");
    @(posedge clk); #1;
    cur_tag = "R12"; ppi_in[1] = 1; bus_en = 1; bus_we = 0; bus_addr = la(0, 'h6c);
    @(posedge clk); #1 bus_en = 0;
    @(negedge clk);
    chk(bus_rdata == 17, "R12", bus_rdata, 17);
    rd_exp(la(0, 'h6c), 33, "R12");
    @(posedge clk); #1 begin spi_in[1] = 0; ppi_in[1] = 0; end
    wr(la(0, 'hb4), 17);
    wr(la(0, 'hb4), 33);
    see(0, 0, "R11");
    repeat (3) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule